// File: doc/BRIEF.md
# Round-Robin Shared Bus Arbiter

This block decides which of several bus masters owns a shared system bus. Every master has its own request line and its own grant line; the arbiter keeps exactly one grant line high at all times. Ownership moves only at a clock edge where the slave's wait response is low. A transfer that a slave is stretching is therefore never cut off: the grant, the owner index and the parked flag stay frozen until the current transfer completes.

Fairness comes from round-robin priority. When the current owner drops its request, the search for the next owner starts at the master just above it in index order and wraps around. A master that keeps its request high keeps the bus. When nobody requests, the bus parks on master 0. The parked flag tells that master to issue address-only transfers. All outputs come from registers. The asynchronous active-low reset passes through a two-stage synchroniser before it releases the arbitration state.

Top module: `bus_rr_arbiter`

## Requirements
- R1: While rst_n is low, and for the first two rising clock edges after rst_n goes high, grant has only bit 0 set, owner is 0 and parked is 1.
- R2: At every clock edge after reset, grant has exactly one bit set.
- R3: At a rising edge where bus_wait is 1, grant, owner and parked keep their values.
- R4: At a rising edge where bus_wait is 0 and the current owner's request bit is 1, that master stays the owner and parked becomes 0.
- R5: At a rising edge where bus_wait is 0, the owner's request bit is 0 and at least one request bit is 1, the bus goes to the first requesting master in the order owner+1, owner+2, … modulo the master count, and parked becomes 0.
- R6: At a rising edge where bus_wait is 0 and all request bits are 0, the bus goes to master 0 and parked becomes 1.
- R7: owner always holds the binary index of the single set bit of grant.
- R8: Outputs change only at rising clock edges. They reflect the req and bus_wait values sampled at the edge just before, so no input reaches an output combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | NUM_MASTERS | One request bit per master |
| bus_wait | input | 1 | Slave wait response; 1 stretches the current transfer and freezes ownership |
| grant | output | NUM_MASTERS | One-hot registered grant, one bit per master |
| owner | output | $clog2(NUM_MASTERS) | Index of the granted master |
| parked | output | 1 | 1 when the default master holds the bus because nobody requested |

## Verification
Each arbitration result is due one clock edge after the req and bus_wait values it depends on. The exception is the two edges after reset release, when the result is due only at the third edge. The bench changes inputs on falling edges and advances a behavioural model by one step per rising edge. At the next falling edge it compares grant, owner and parked against that model, so every comparison lands exactly one register stage after its stimulus. Directed phases cover a wait-held handover, owner retention, wrap-around priority and parking. A long run with random requests and random wait then follows, with a reset in the middle of it.

// File: rtl/arb_pkg.sv
package arb_pkg;

  localparam int unsigned ARB_MAX_MASTERS = 8;

  typedef enum logic [1:0] {
    DEC_KEEP     = 2'd0,
    DEC_HANDOVER = 2'd1,
    DEC_PARK     = 2'd2
  } arb_decision_e;

endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] cur,
  output logic [IW-1:0] pick,
  output logic          found
);

  logic [IW-1:0] cand [N];

  // candidate k sits k+1 places above the current owner, wrapping at N
  for (genvar k = 0; k < N; k++) begin : g_cand
    always_comb begin
      if ({1'b0, cur} + (IW+1)'(k + 1) >= (IW+1)'(N)) begin
        cand[k] = IW'({1'b0, cur} + (IW+1)'(k + 1) - (IW+1)'(N));
      end else begin
        cand[k] = IW'({1'b0, cur} + (IW+1)'(k + 1));
      end
    end
  end

  // walk from the farthest candidate to the nearest so the nearest wins
  always_comb begin
    pick  = cur;
    found = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[cand[k]]) begin
        pick  = cand[k];
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/arb_owner_reg.sv
module arb_owner_reg #(
  parameter int unsigned N   = 4,
  parameter int unsigned IW  = 2,
  parameter int unsigned DEF = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [IW-1:0] idx_d,
  input  logic [N-1:0]  grant_d,
  input  logic          park_d,
  output logic [IW-1:0] idx_q,
  output logic [N-1:0]  grant_q,
  output logic          park_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= IW'(DEF);
      grant_q <= N'(1) << DEF;
      park_q  <= 1'b1;
    end else if (en) begin
      idx_q   <= idx_d;
      grant_q <= grant_d;
      park_q  <= park_d;
    end
  end

endmodule

// File: rtl/bus_rr_arbiter.sv
module bus_rr_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned NUM_MASTERS    = 4,
  parameter int unsigned DEFAULT_MASTER = 0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_MASTERS-1:0]         req,
  input  logic                           bus_wait,
  output logic [NUM_MASTERS-1:0]         grant,
  output logic [$clog2(NUM_MASTERS)-1:0] owner,
  output logic                           parked
);

  localparam int unsigned IW = $clog2(NUM_MASTERS);

  logic                   rst_q_n;
  logic [IW-1:0]          idx_q;
  logic [NUM_MASTERS-1:0] grant_q;
  logic                   park_q;
  logic [IW-1:0]          rr_pick;
  logic                   rr_found;
  arb_decision_e          decision;
  logic [IW-1:0]          idx_d;
  logic [NUM_MASTERS-1:0] grant_d;
  logic                   park_d;
  logic                   upd_en;

  arb_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  arb_rr_pick #(
    .N  (NUM_MASTERS),
    .IW (IW)
  ) u_pick (
    .req   (req),
    .cur   (idx_q),
    .pick  (rr_pick),
    .found (rr_found)
  );

  // decision: hold, rotate or park
  always_comb begin
    if (req[idx_q]) begin
      decision = DEC_KEEP;
    end else if (rr_found) begin
      decision = DEC_HANDOVER;
    end else begin
      decision = DEC_PARK;
    end
  end

  always_comb begin
    unique case (decision)
      DEC_KEEP: begin
        idx_d  = idx_q;
        park_d = 1'b0;
      end
      DEC_HANDOVER: begin
        idx_d  = rr_pick;
        park_d = 1'b0;
      end
      default: begin
        idx_d  = IW'(DEFAULT_MASTER);
        park_d = 1'b1;
      end
    endcase
  end

  for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_dec
    assign grant_d[g] = (idx_d == IW'(g));
  end

  // ownership only moves when the slave is not stretching a transfer
  assign upd_en = ~bus_wait;

  arb_owner_reg #(
    .N   (NUM_MASTERS),
    .IW  (IW),
    .DEF (DEFAULT_MASTER)
  ) u_state (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .en      (upd_en),
    .idx_d   (idx_d),
    .grant_d (grant_d),
    .park_d  (park_d),
    .idx_q   (idx_q),
    .grant_q (grant_q),
    .park_q  (park_q)
  );

  assign grant  = grant_q;
  assign owner  = idx_q;
  assign parked = park_q;

endmodule

// File: rtl/bus_rr_arbiter_chk.sv
module bus_rr_arbiter_chk #(
  parameter int unsigned N   = 4,
  parameter int unsigned IW  = 2,
  parameter int unsigned DEF = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req,
  input logic          bus_wait,
  input logic [N-1:0]  grant,
  input logic [IW-1:0] owner,
  input logic          parked
);

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) == 1);

  a_r3_wait_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wait |=> ($stable(grant) && $stable(owner) && $stable(parked)));

  a_r4_owner_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wait && ((req & grant) != '0)) |=> ($stable(grant) && !parked));

  a_r5_goes_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wait && ((req & grant) == '0) && (req != '0))
      |=> (((grant & $past(req)) != '0) && !parked));

  a_r6_park_default: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wait && (req == '0)) |=> ((grant == (N'(1) << DEF)) && parked));

  a_r7_owner_index: assert property (@(posedge clk) disable iff (!rst_n)
    grant == (N'(1) << owner));

endmodule

bind bus_rr_arbiter bus_rr_arbiter_chk #(
  .N   (NUM_MASTERS),
  .IW  (IW),
  .DEF (DEFAULT_MASTER)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .req      (req),
  .bus_wait (bus_wait),
  .grant    (grant),
  .owner    (owner),
  .parked   (parked)
);

// File: tb/sim_bus_rr_arbiter.sv
module sim_bus_rr_arbiter;

  localparam int N  = 4;
  localparam int IW = 2;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  req;
  logic          bus_wait;
  logic [N-1:0]  grant;
  logic [IW-1:0] owner;
  logic          parked;

  int n_checks;
  int n_fail;

  // behavioural model state: expected outputs after the next rising edge
  int m_idx;
  bit m_park;
  int m_rcnt;

  bus_rr_arbiter #(.NUM_MASTERS(N), .DEFAULT_MASTER(0)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .bus_wait (bus_wait),
    .grant    (grant),
    .owner    (owner),
    .parked   (parked)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input bit ok, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    int ones;
    ones = $countones(grant);
    check(tag, int'(owner) == m_idx, "owner", int'(owner), m_idx);
    check(tag, parked == m_park, "parked", int'(parked), int'(m_park));
    check(tag, grant == (N'(1) << m_idx), "grant", int'(grant), 1 << m_idx);
    check("R2", ones == 1, "grant ones", ones, 1);
    check("R7", grant == (N'(1) << owner), "grant vs owner", int'(grant), 1 << owner);
  endtask

  // one model step per rising edge
  task automatic model_step();
    bit found;
    int nxt;
    if (!rst_n) begin
      m_idx = 0; m_park = 1; m_rcnt = 0;
    end else if (m_rcnt < 2) begin
      m_rcnt++;
    end else if (!bus_wait) begin
      if (req[m_idx]) begin
        m_park = 0;
      end else begin
        found = 0; nxt = 0;
        for (int k = 1; k <= N; k++) begin
          if (!found && req[(m_idx + k) % N]) begin
            found = 1; nxt = (m_idx + k) % N;
          end
        end
        if (found) begin m_idx = nxt; m_park = 0; end
        else begin m_idx = 0; m_park = 1; end
      end
    end
  endtask

  task automatic step(input logic [N-1:0] r, input logic w, input string tag);
    @(negedge clk);
    compare(tag);
    req = r;
    bus_wait = w;
    model_step();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_idx = 0; m_park = 1; m_rcnt = 0;
    #1 compare("R1");
    step(4'b1010, 1'b0, "R1");
    step(4'b0110, 1'b0, "R1");
    @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    req = 4'b0100; bus_wait = 1'b0;
    model_step();
    step(4'b0100, 1'b0, "R1");
    step(4'b0100, 1'b0, "R1");
  endtask

  initial begin
    #2000000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    n_checks = 0; n_fail = 0;
    rst_n = 1'b0; req = '0; bus_wait = 1'b0;
    m_idx = 0; m_park = 1; m_rcnt = 0;
    do_reset();

    // R6: idle bus parks on master 0
    step(4'b0000, 1'b0, "R6");
    step(4'b0000, 1'b0, "R6");
    // R3: master 2 asks while a transfer is stretched: nothing moves
    step(4'b0100, 1'b1, "R3");
    step(4'b0100, 1'b1, "R3");
    step(4'b0100, 1'b0, "R3");
    // R8: grant to master 2 appears one edge after wait drops
    step(4'b0100, 1'b0, "R8");
    // R4: owner keeps bus while others also ask
    step(4'b1110, 1'b0, "R4");
    step(4'b1110, 1'b0, "R4");
    // R5: owner 2 releases, next after 2 is 3
    step(4'b1010, 1'b0, "R5");
    step(4'b0011, 1'b0, "R5");
    // R5: wrap-around from 3 to 0
    step(4'b0011, 1'b0, "R5");
    step(4'b0010, 1'b0, "R5");
    // R3: handover held by wait, then released
    step(4'b1000, 1'b1, "R3");
    step(4'b1000, 1'b1, "R3");
    step(4'b1000, 1'b0, "R3");
    // R6: everyone drops
    step(4'b0000, 1'b0, "R6");
    step(4'b0001, 1'b0, "R4");
    step(4'b0001, 1'b0, "R4");

    for (int i = 0; i < 3000; i++) begin
      step(N'($urandom), ($urandom % 3) == 0, "R5");
      if (i == 1500) do_reset();
    end
    step(4'b0000, 1'b0, "R6");
    step(4'b0000, 1'b0, "R6");
    @(negedge clk);
    compare("R6");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule